// File: doc/BRIEF.md
# Reset Sequencer with Start-up Timers

This block collects every reset request of a small processor core and turns them into one synchronous chip-reset output. Supply-rise and brown-out events come in from analog detectors as one-cycle digital pulses. These two events start a two-stage release sequence. A power-up timer counts a slow periodic tick. After it, an oscillator start-up timer counts oscillator clock-edge strobes. The chip reset stays asserted until both stages finish. All other reset requests only hold the chip in reset briefly. They do not touch the timers.

A seven-bit status register records which event caused the last reset. Its five low bits are active-low cause flags: the matching event clears a flag, and software writes it back to 1. The two upper bits are software control bits. One enables interrupt priority. The other turns on brown-out detection when the brown-out configuration selects software control. The two stack reset causes are recorded on their own sticky outputs.

Top module: `rst_seq_ctrl`

## Requirements
- R1: Every accepted reset source asserts `chip_rst` on the first clock edge that samples its strobe. The sources are power-on, brown-out, pin reset in run mode, pin reset in a low-power mode, watchdog, software reset instruction, stack full and stack underflow.
- R2: While `pin_rst_en` is 0, both pin reset requests are ignored. They do not assert `chip_rst` and they change no status bit.
- R3: After a power-on or brown-out event sampled at edge E, with both timers enabled, the power-up stage needs 2048 `slow_tick` strobes, starting one cycle after E. The oscillator stage then needs 1024 `osc_edge` strobes. `chip_rst` falls two edges after the final strobe. With both strobes held high, `chip_rst` is therefore high for 3074 cycles.
- R4: A timer stage whose enable input is 0 completes one cycle after it is reached. The sequence lengths with strobes held high are: power-up timer only, 2051 cycles; oscillator timer only, 1027 cycles; neither timer, 4 cycles.
- R5: Sources other than power-on and brown-out hold `chip_rst` high for exactly two cycles when no timed sequence is running. They neither restart nor shorten a sequence that is running.
- R6: A brown-out accepted while a sequence is running restarts both timers from zero. The release then comes the full sequence length after that brown-out.
- R7: `stat_q` bit layout: bit0 brown-out flag, bit1 power-on flag, bit2 power-down flag, bit3 time-out flag, bit4 reset-instruction flag, bit5 software brown-out enable, bit6 interrupt-priority enable. Power-on loads 0x3C. Brown-out clears bit0, low-power pin reset clears bit2, watchdog clears bit3, and the reset instruction clears bit4. Run-mode pin and stack resets leave the register unchanged.
- R8: A write (`stat_we`) stores all seven bits of `stat_wdata`. When a write and an event hit the same edge, the event's flag clear wins for that bit.
- R9: `bor_cfg` sets how brown-out pulses are handled: 0 ignores them, 1 accepts them only while bit5 is 1, and 2 or 3 always accepts them.
- R10: `stk_full_flag` and `stk_under_flag` are set by their stack resets and cleared only by power-on or `rst_n`.
- R11: While `rst_n` is low, the block behaves as after power-on: `stat_q` is 0x3C, the stack flags are 0 and `chip_rst` is 1. The timed sequence starts from the last low edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, treated as power-on |
| por_pulse | input | 1 | Supply-rise event strobe |
| bor_pulse | input | 1 | Brown-out event strobe |
| pin_run_req | input | 1 | External pin reset request, run mode |
| pin_lp_req | input | 1 | External pin reset request, low-power mode |
| wdt_req | input | 1 | Watchdog time-out strobe |
| swrst_req | input | 1 | Reset instruction strobe |
| stk_full_req | input | 1 | Stack full reset strobe |
| stk_under_req | input | 1 | Stack underflow reset strobe |
| pin_rst_en | input | 1 | Configuration: pin reset enabled |
| bor_cfg | input | 2 | Brown-out mode: 0 off, 1 software, 2/3 on |
| pwrt_en | input | 1 | Power-up timer enable |
| ost_en | input | 1 | Oscillator start-up timer enable |
| slow_tick | input | 1 | Slow periodic tick strobe for the power-up timer |
| osc_edge | input | 1 | Oscillator edge strobe for the start-up timer |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | 7 | Status register write data |
| stat_q | output | 7 | Status register contents |
| stk_full_flag | output | 1 | Sticky stack full reset flag |
| stk_under_flag | output | 1 | Sticky stack underflow reset flag |
| chip_rst | output | 1 | Chip reset, active high |

## Verification
A wrong timer count or a missed restart shows up only as the cycle in which `chip_rst` falls. That can be thousands of cycles after the cause, so the bench measures each sequence length to the exact cycle. It also injects a brown-out and a watchdog request in mid-sequence. A wrong flag update or a wrong gating decision is visible on `stat_q` and `chip_rst` on the very next edge. Random single-source strobes mixed with software writes are compared there against a bench model of the register.

// File: rtl/rstc_pkg.sv
// Shared types and constants for the reset sequencer.
// Assumes a seven-bit status register with cause flags in the low five bits.
package rstc_pkg;

    // How brown-out pulses are handled
    typedef enum logic [1:0] {
        BOR_OFF    = 2'd0,
        BOR_SOFT   = 2'd1,
        BOR_ON     = 2'd2,
        BOR_ON_ALT = 2'd3
    } bor_cfg_e;

    // One bit per reset source
    typedef struct packed {
        logic por;
        logic bor;
        logic pin_run;
        logic pin_lp;
        logic wdt;
        logic swrst;
        logic stk_full;
        logic stk_under;
    } src_t;

    localparam int STAT_W   = 7;
    localparam int FLG_BOR  = 0;
    localparam int FLG_POR  = 1;
    localparam int FLG_PD   = 2;
    localparam int FLG_TO   = 3;
    localparam int FLG_RI   = 4;
    localparam int BIT_SBOR = 5;
    localparam int BIT_IPRI = 6;
    localparam logic [STAT_W-1:0] POR_VAL = 7'h3C;

endpackage

// File: rtl/rstc_src_merge.sv
// Qualifies raw reset strobes against configuration and splits them into
// long (timed) and short (held) events. Purely combinational.
// Assumes the software brown-out bit comes from a register (no loop).
module rstc_src_merge
    import rstc_pkg::*;
(
    input  src_t        req,
    input  logic        pin_en,
    input  logic [1:0]  bor_cfg,
    input  logic        sbor_bit,
    output src_t        acc,
    output logic        long_ev,
    output logic        short_ev
);

    bor_cfg_e cfg;
    logic     bor_ok;

    // Decide whether brown-out pulses are honoured in the current mode
    always_comb begin
        cfg = bor_cfg_e'(bor_cfg);
        case (cfg)
            BOR_OFF:  bor_ok = 1'b0;
            BOR_SOFT: bor_ok = sbor_bit;
            default:  bor_ok = 1'b1;
        endcase
    end

    // Gate each source and classify it
    always_comb begin
        acc         = req;
        acc.bor     = req.bor & bor_ok;
        acc.pin_run = req.pin_run & pin_en;
        acc.pin_lp  = req.pin_lp & pin_en;
        long_ev     = acc.por | acc.bor;
        short_ev    = acc.pin_run | acc.pin_lp | acc.wdt | acc.swrst
                    | acc.stk_full | acc.stk_under;
    end

endmodule

// File: rtl/rstc_stage.sv
// One start-up timer stage: counts 2**W step strobes while enabled and
// reached (go), then holds done until restarted. A disabled stage
// completes one cycle after it is reached.
// Assumes restart and rst_n both clear the stage synchronously.
module rstc_stage #(
    parameter int W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic go,
    input  logic en,
    input  logic step,
    output logic done
);

    localparam logic [W-1:0] LAST = '1;

    logic [W-1:0] cnt;

    // Count step strobes until the last count, or skip when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (go && !done) begin
            if (!en) begin
                done <= 1'b1;
            end else if (step) begin
                if (cnt == LAST) begin
                    done <= 1'b1;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4
    skip_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !done && !en && !restart) |=> done);

    // R3
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(go));

    // R6
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !done);

endmodule

// File: rtl/rstc_status.sv
// Status register with active-low cause flags and two software bits,
// plus sticky stack reset flags kept outside the register.
// Assumes power-on has priority over events, and events over writes.
module rstc_status
    import rstc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  src_t              acc,
    input  logic              we,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] stat_q,
    output logic              stkf_q,
    output logic              stku_q
);

    logic [STAT_W-1:0] stat_nxt;

    // Apply a software write, then let events clear their flags
    always_comb begin
        stat_nxt = we ? wdata : stat_q;
        if (acc.bor)    stat_nxt[FLG_BOR] = 1'b0;
        if (acc.pin_lp) stat_nxt[FLG_PD]  = 1'b0;
        if (acc.wdt)    stat_nxt[FLG_TO]  = 1'b0;
        if (acc.swrst)  stat_nxt[FLG_RI]  = 1'b0;
    end

    // Hold the register and the sticky stack flags
    always_ff @(posedge clk) begin
        if (!rst_n || acc.por) begin
            stat_q <= POR_VAL;
            stkf_q <= 1'b0;
            stku_q <= 1'b0;
        end else begin
            stat_q <= stat_nxt;
            if (acc.stk_full)  stkf_q <= 1'b1;
            if (acc.stk_under) stku_q <= 1'b1;
        end
    end

    // R7
    por_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc.por |=> (stat_q == POR_VAL));

    // R7
    wdt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.wdt && !acc.por) |=> !stat_q[FLG_TO]);

    // R10
    stk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.stk_full && !acc.por) |=> stkf_q);

endmodule

// File: rtl/rst_seq_ctrl.sv
// Reset sequencer top: merges reset sources, holds chip_rst in a
// set/reset register, and releases it after a short hold or, for
// power-on/brown-out, after the cascaded power-up and oscillator timers.
// Assumes all request inputs are synchronous single-cycle strobes.
module rst_seq_ctrl
    import rstc_pkg::*;
#(
    parameter int PWRT_W   = 11,
    parameter int OST_W    = 10,
    parameter int HOLD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_pulse,
    input  logic              bor_pulse,
    input  logic              pin_run_req,
    input  logic              pin_lp_req,
    input  logic              wdt_req,
    input  logic              swrst_req,
    input  logic              stk_full_req,
    input  logic              stk_under_req,
    input  logic              pin_rst_en,
    input  logic [1:0]        bor_cfg,
    input  logic              pwrt_en,
    input  logic              ost_en,
    input  logic              slow_tick,
    input  logic              osc_edge,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] stat_q,
    output logic              stk_full_flag,
    output logic              stk_under_flag,
    output logic              chip_rst
);

    localparam int HOLD_W = $clog2(HOLD_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYC - 1);

    src_t              req, acc;
    logic              long_ev, short_ev;
    logic              seq_active, pwrt_done, ost_done;
    logic [HOLD_W-1:0] hold;

    // Collect the raw strobes into one source vector
    always_comb begin
        req.por       = por_pulse;
        req.bor       = bor_pulse;
        req.pin_run   = pin_run_req;
        req.pin_lp    = pin_lp_req;
        req.wdt       = wdt_req;
        req.swrst     = swrst_req;
        req.stk_full  = stk_full_req;
        req.stk_under = stk_under_req;
    end

    rstc_src_merge u_merge (
        .req      (req),
        .pin_en   (pin_rst_en),
        .bor_cfg  (bor_cfg),
        .sbor_bit (stat_q[BIT_SBOR]),
        .acc      (acc),
        .long_ev  (long_ev),
        .short_ev (short_ev)
    );

    rstc_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .we     (stat_we),
        .wdata  (stat_wdata),
        .stat_q (stat_q),
        .stkf_q (stk_full_flag),
        .stku_q (stk_under_flag)
    );

    rstc_stage #(.W(PWRT_W)) u_pwrt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (long_ev),
        .go      (seq_active),
        .en      (pwrt_en),
        .step    (slow_tick),
        .done    (pwrt_done)
    );

    rstc_stage #(.W(OST_W)) u_ost (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (long_ev),
        .go      (seq_active & pwrt_done),
        .en      (ost_en),
        .step    (osc_edge),
        .done    (ost_done)
    );

    // Set on any source; release after the hold and any timed sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_rst   <= 1'b1;
            seq_active <= 1'b1;
            hold       <= '0;
        end else if (long_ev || short_ev) begin
            chip_rst <= 1'b1;
            hold     <= HOLD_LOAD;
            if (long_ev)                     seq_active <= 1'b1;
            else if (seq_active && ost_done) seq_active <= 1'b0;
        end else begin
            if (seq_active && ost_done) seq_active <= 1'b0;
            if (hold != '0)       hold     <= hold - 1'b1;
            else if (!seq_active) chip_rst <= 1'b0;
        end
    end

    // R1
    any_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (long_ev || short_ev) |=> chip_rst);

    // R5
    short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_ev |=> chip_rst ##1 chip_rst);

    // R3
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chip_rst) |-> $past(!seq_active && !pwrt_en | pwrt_done));

endmodule

// File: tb/rst_seq_ctrl_tb.sv
`timescale 1ns/1ps
module rst_seq_ctrl_tb;

    localparam int PW = 2048;
    localparam int OW = 1024;
    localparam int LIMIT = 10000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] ev;
    logic       pin_rst_en, pwrt_en, ost_en, slow_tick, osc_edge, stat_we;
    logic [1:0] bor_cfg;
    logic [6:0] stat_wdata, stat_q;
    logic       stk_full_flag, stk_under_flag, chip_rst;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [6:0] exp_stat;
    logic       exp_sf, exp_su;

    always #2 clk = ~clk;

    rst_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .por_pulse(ev[0]), .bor_pulse(ev[1]), .pin_run_req(ev[2]),
        .pin_lp_req(ev[3]), .wdt_req(ev[4]), .swrst_req(ev[5]),
        .stk_full_req(ev[6]), .stk_under_req(ev[7]),
        .pin_rst_en(pin_rst_en), .bor_cfg(bor_cfg),
        .pwrt_en(pwrt_en), .ost_en(ost_en),
        .slow_tick(slow_tick), .osc_edge(osc_edge),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .stat_q(stat_q), .stk_full_flag(stk_full_flag),
        .stk_under_flag(stk_under_flag), .chip_rst(chip_rst)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Expected status after one edge, from R7/R8
    function automatic logic [6:0] next_stat(input logic [6:0] cur, input logic [7:0] acc,
                                             input logic we, input logic [6:0] wd);
        logic [6:0] s;
        if (acc[0]) return 7'h3C;
        s = we ? wd : cur;
        if (acc[1]) s[0] = 1'b0;
        if (acc[3]) s[2] = 1'b0;
        if (acc[4]) s[3] = 1'b0;
        if (acc[5]) s[4] = 1'b0;
        return s;
    endfunction

    // Sequence length in cycles with both strobes held high (R3/R4)
    function automatic int seq_len(input logic pe, input logic oe);
        return (pe ? PW : 1) + (oe ? OW : 1) + 2;
    endfunction

    // Drive one cycle of requests and an optional write
    task automatic drive(input logic [7:0] e, input logic we, input logic [6:0] wd);
        ev = e; stat_we = we; stat_wdata = wd;
        @(negedge clk);
        ev = '0; stat_we = 1'b0;
    endtask

    // Count cycles chip_rst stays high, current sample being the first
    task automatic measure(output int n, input int inj_at, input logic [7:0] inj);
        n = 1;
        while (n < LIMIT) begin
            ev = (n == inj_at) ? inj : 8'h00;
            @(negedge clk);
            ev = '0;
            if (!chip_rst) break;
            n++;
        end
    endtask

    initial begin
        int n;
        logic [7:0] e, a;
        logic we;
        logic [6:0] wd;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; ev = '0; pin_rst_en = 1'b1; bor_cfg = 2'd2;
        pwrt_en = 1'b1; ost_en = 1'b1; slow_tick = 1'b1; osc_edge = 1'b1;
        stat_we = 1'b0; stat_wdata = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(stat_q == 7'h3C, "R11 stat", stat_q, 7'h3C);
        chk(chip_rst == 1'b1, "R11 chip_rst", chip_rst, 1);
        chk({stk_full_flag, stk_under_flag} == 2'b00, "R11 stack flags",
            {stk_full_flag, stk_under_flag}, 0);
        rst_n = 1'b1;
        measure(n, 0, 8'h00);
        chk(n == seq_len(1, 1), "R11 release after reset", n, seq_len(1, 1));

        // R3 R4: all timer enable combinations after power-on
        for (int k = 0; k < 4; k++) begin
            pwrt_en = k[1]; ost_en = k[0];
            drive(8'h01, 1'b0, 7'h00);
            chk(chip_rst == 1'b1, "R1 por asserts", chip_rst, 1);
            measure(n, 0, 8'h00);
            chk(n == seq_len(k[1], k[0]), "R3 R4 sequence length", n, seq_len(k[1], k[0]));
        end
        pwrt_en = 1'b1; ost_en = 1'b1;

        // R6: brown-out in mid-sequence restarts timing
        drive(8'h01, 1'b0, 7'h00);
        measure(n, 700, 8'h02);
        chk(n == 700 + seq_len(1, 1), "R6 restart by brown-out", n, 700 + seq_len(1, 1));
        chk(stat_q[0] == 1'b0, "R6 R7 bor flag", stat_q[0], 0);

        // R5: watchdog in mid-sequence neither restarts nor shortens
        drive(8'h01, 1'b0, 7'h00);
        measure(n, 500, 8'h10);
        chk(n == seq_len(1, 1), "R5 short source in sequence", n, seq_len(1, 1));
        chk(stat_q == 7'h34, "R5 R7 wdt flag", stat_q, 7'h34);

        // R9: brown-out configuration modes (timers disabled)
        pwrt_en = 1'b0; ost_en = 1'b0;
        drive(8'h01, 1'b0, 7'h00);
        measure(n, 0, 8'h00);
        drive(8'h00, 1'b1, 7'h3F);
        bor_cfg = 2'd1;
        drive(8'h02, 1'b0, 7'h00);
        chk(chip_rst == 1'b1, "R9 soft mode with bit5 set", chip_rst, 1);
        chk(stat_q == 7'h3E, "R9 R7 bor flag", stat_q, 7'h3E);
        measure(n, 0, 8'h00);
        chk(n == 4, "R9 R4 bor sequence", n, 4);
        drive(8'h00, 1'b1, 7'h1F);
        drive(8'h02, 1'b0, 7'h00);
        chk(chip_rst == 1'b0, "R9 soft mode with bit5 clear", chip_rst, 0);
        chk(stat_q == 7'h1F, "R9 ignored bor", stat_q, 7'h1F);
        bor_cfg = 2'd3;
        drive(8'h02, 1'b0, 7'h00);
        chk(chip_rst == 1'b1, "R9 always-on mode", chip_rst, 1);
        chk(stat_q == 7'h1E, "R9 bor flag", stat_q, 7'h1E);
        measure(n, 0, 8'h00);
        bor_cfg = 2'd0;
        drive(8'h00, 1'b1, 7'h3F);
        drive(8'h02, 1'b0, 7'h00);
        repeat (2) @(negedge clk);
        chk(chip_rst == 1'b0, "R9 off mode", chip_rst, 0);
        chk(stat_q == 7'h3F, "R9 off mode flags", stat_q, 7'h3F);

        // R8: event wins over a same-cycle write
        drive(8'h10, 1'b1, 7'h7F);
        chk(stat_q == 7'h77, "R8 event over write", stat_q, 7'h77);
        repeat (2) @(negedge clk);

        // R10: stack flag kept until power-on
        drive(8'h40, 1'b0, 7'h00);
        chk(stk_full_flag == 1'b1, "R10 stack full set", stk_full_flag, 1);
        chk(stat_q == 7'h77, "R10 status untouched", stat_q, 7'h77);
        repeat (4) @(negedge clk);
        drive(8'h01, 1'b0, 7'h00);
        chk(stk_full_flag == 1'b0, "R10 cleared by power-on", stk_full_flag, 0);
        measure(n, 0, 8'h00);

        // Random single-source strobes with writes (R1 R2 R5 R7 R8 R10)
        exp_stat = stat_q; exp_sf = 1'b0; exp_su = 1'b0;
        for (int i = 0; i < 300; i++) begin
            int op;
            op = $urandom_range(0, 8);
            pin_rst_en = 1'($urandom_range(0, 1));
            bor_cfg = 2'd0;
            e = (op < 7) ? (8'h01 << (op + 1)) : 8'h00;
            a = e;
            if (!pin_rst_en) a[3:2] = 2'b00;
            a[1] = 1'b0;
            we = ($urandom_range(0, 3) == 0);
            wd = 7'($urandom_range(0, 127));
            exp_stat = next_stat(exp_stat, a, we, wd);
            if (a[6]) exp_sf = 1'b1;
            if (a[7]) exp_su = 1'b1;
            drive(e, we, wd);
            chk(stat_q == exp_stat, "R7 R8 R2 random status", stat_q, exp_stat);
            chk(chip_rst == (a != 0), "R1 R2 random chip_rst", chip_rst, (a != 0));
            chk({stk_full_flag, stk_under_flag} == {exp_sf, exp_su}, "R10 random stack",
                {stk_full_flag, stk_under_flag}, {exp_sf, exp_su});
            @(negedge clk);
            chk(chip_rst == (a != 0), "R5 second hold cycle", chip_rst, (a != 0));
            @(negedge clk);
            chk(chip_rst == 1'b0, "R5 short release", chip_rst, 0);
        end
        finish_run();
    end

endmodule